// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces refresh requests for a memory built from two independently selected ranks. Each rank has its own down-counting interval timer. When the timer runs out, the block raises that rank's refresh request. The request stays up until the memory controller returns an acknowledge pulse for that rank. If a timer runs out again while a request is still waiting, the missed refresh is added to a per-rank debt count. The controller reads this count to learn how far behind the rank has fallen.

In the normal temperature range the interval is NORM_CYCLES clock cycles. This is about 7.8 µs, so 8192 refreshes fit in 64 ms. When the hot-range flag is set, each later reload uses half that value. This doubles the rate so that 8192 refreshes fit in 32 ms. A flag change does not disturb a count that is already running. A global enable can stop all timers. Acknowledges are still handled while the timers are stopped.

Top module: `refresh_sched`

## Requirements
- R1: While reset is low and in the cycle after it is released, every request is 0 and every debt count is 0. Each timer restarts at the full normal interval.
- R2: With enable high and the hot flag low from reset release onward, a rank's request is first seen high exactly NORM_CYCLES cycles after reset release. Later timer expiries are NORM_CYCLES enabled cycles apart.
- R3: A timer reload that happens while the hot flag is high uses NORM_CYCLES/2. The next expiry therefore comes NORM_CYCLES/2 enabled cycles after that reload.
- R4: Changing the hot flag part-way through an interval does not restart or shorten the count in progress. Only the next reload is affected.
- R5: A request stays high until an acknowledge for that rank arrives. An acknowledge while the request is low has no effect.
- R6: An expiry while the request is already high adds one to that rank's debt. The debt stops at 8 and never exceeds it.
- R7: An acknowledge while the debt is above zero lowers the debt by one and keeps the request high. If an acknowledge and an expiry arrive in the same cycle while a request is pending, both request and debt stay unchanged.
- R8: With enable low, no timer advances and no new request or debt appears. Acknowledges are still served.
- R9: Each rank's request and debt depend only on its own acknowledge. Rank r's debt sits in bits [4r+3:4r] of the debt port as an unsigned count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_en | input | 1 | Timers advance only while high |
| hot_range | input | 1 | High selects the halved interval for the next reloads |
| rank_ack | input | NRANK | One-cycle acknowledge per rank |
| rank_req | output | NRANK | Refresh request per rank |
| rank_debt | output | NRANK*DW | Postponed-refresh count per rank, 4 bits each by default |

## Verification
Several directed runs each isolate one behaviour. The first-request latency after reset separates a correct interval from off-by-one loads. The hot flag is raised a few cycles into an interval; this shows whether a change restarts the count or only affects the next reload. A long run without acknowledges drives the debt to its ceiling. A series of acknowledges on one rank only then separates serving a debt from clearing a request, and shows that the ranks do not share state. A pseudo-random sweep of enable, hot flag and both acknowledges follows. It is compared every cycle against an arithmetic model of the interval and the debt. This sweep covers the same-cycle acknowledge-and-expiry case and acknowledges that arrive while the timers are stopped.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    // Events seen by a rank ledger in one cycle: {expiry, served acknowledge}
    typedef enum logic [1:0] {
        LEDGER_IDLE  = 2'b00,
        LEDGER_SERVE = 2'b01,
        LEDGER_TICK  = 2'b10,
        LEDGER_BOTH  = 2'b11
    } ledger_ev_e;

    localparam int DEBT_CAP_DEFAULT = 8;

endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int NORM_CYCLES = 1950,
    parameter int CW          = $clog2(NORM_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hot,
    output logic expire
);
    localparam int HALF_CYCLES = NORM_CYCLES / 2;
    localparam logic [CW-1:0] LOAD_NORM = CW'(NORM_CYCLES - 1);
    localparam logic [CW-1:0] LOAD_HOT  = CW'(HALF_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d   = tm_q;
        expire = run && (tm_q.cnt == '0);
        if (run) begin
            if (tm_q.cnt == '0) begin
                tm_d.cnt = hot ? LOAD_HOT : LOAD_NORM;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q.cnt <= LOAD_NORM;
        end else begin
            tm_q <= tm_d;
        end
    end

    // R8
    timer_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(tm_q.cnt));

    // R3
    timer_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && hot) |=> (tm_q.cnt == LOAD_HOT));

    // R2
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.cnt <= LOAD_NORM);

endmodule

// File: rtl/rank_ledger.sv
module rank_ledger
    import refsched_pkg::*;
#(
    parameter int DEBT_CAP = DEBT_CAP_DEFAULT,
    parameter int DW       = $clog2(DEBT_CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expire,
    input  logic          ack,
    output logic          req,
    output logic [DW-1:0] debt
);
    localparam logic [DW-1:0] CAP = DW'(DEBT_CAP);

    typedef struct packed {
        logic          req;
        logic [DW-1:0] debt;
    } ledger_t;

    ledger_t    lg_d, lg_q;
    ledger_ev_e ev;

    always_comb begin
        lg_d = lg_q;
        ev   = ledger_ev_e'({expire, ack && lg_q.req});
        unique case (ev)
            LEDGER_TICK: begin
                if (!lg_q.req) begin
                    lg_d.req = 1'b1;
                end else if (lg_q.debt < CAP) begin
                    lg_d.debt = lg_q.debt + 1'b1;
                end
            end
            LEDGER_SERVE: begin
                if (lg_q.debt != '0) begin
                    lg_d.debt = lg_q.debt - 1'b1;
                end else begin
                    lg_d.req = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q <= '0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign req  = lg_q.req;
    assign debt = lg_q.debt;

    // R6
    ledger_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lg_q.debt <= CAP);

    // R5
    ledger_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lg_q.req) |-> $past(ack));

    // R7
    ledger_debt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_q.debt != '0) |-> lg_q.req);

    // R6
    ledger_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ack && lg_q.req && lg_q.debt < CAP) |=> (lg_q.debt == $past(lg_q.debt) + 1'b1));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int NRANK       = 2,
    parameter int NORM_CYCLES = 1950,
    parameter int DEBT_CAP    = DEBT_CAP_DEFAULT,
    localparam int DW         = $clog2(DEBT_CAP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refresh_en,
    input  logic                hot_range,
    input  logic [NRANK-1:0]    rank_ack,
    output logic [NRANK-1:0]    rank_req,
    output logic [NRANK*DW-1:0] rank_debt
);
    localparam int CW = $clog2(NORM_CYCLES);

    logic [NRANK-1:0] expire_w;

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        interval_timer #(
            .NORM_CYCLES(NORM_CYCLES),
            .CW         (CW)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (refresh_en),
            .hot   (hot_range),
            .expire(expire_w[r])
        );

        rank_ledger #(
            .DEBT_CAP(DEBT_CAP),
            .DW      (DW)
        ) u_ledger (
            .clk   (clk),
            .rst_n (rst_n),
            .expire(expire_w[r]),
            .ack   (rank_ack[r]),
            .req   (rank_req[r]),
            .debt  (rank_debt[r*DW +: DW])
        );
    end

    // R8
    top_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_en && rank_ack == '0) |=> $stable(rank_req));

endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int N    = 8;
    localparam int HALF = N / 2;
    localparam int CAP  = 8;
    localparam int DW   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       hot = 1'b0;
    logic [1:0] ack = 2'b00;
    logic [1:0] req;
    logic [7:0] debt;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    int m_cnt [2];
    int m_req [2];
    int m_debt[2];

    always #2 clk = ~clk;

    refresh_sched #(.NRANK(2), .NORM_CYCLES(N), .DEBT_CAP(CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .refresh_en(en), .hot_range(hot),
        .rank_ack(ack), .rank_req(req), .rank_debt(debt)
    );

    // Arithmetic model from the requirements
    always @(posedge clk) begin
        for (int r = 0; r < 2; r++) begin
            if (!rst_n) begin
                m_cnt[r] = N - 1; m_req[r] = 0; m_debt[r] = 0;
            end else begin
                automatic bit ex = en && (m_cnt[r] == 0);
                automatic bit sv = ack[r] && (m_req[r] != 0);
                if (en) m_cnt[r] = (m_cnt[r] == 0) ? (hot ? HALF - 1 : N - 1) : m_cnt[r] - 1;
                if (ex && !sv) begin
                    if (m_req[r] == 0) m_req[r] = 1;
                    else if (m_debt[r] < CAP) m_debt[r] = m_debt[r] + 1;
                end else if (sv && !ex) begin
                    if (m_debt[r] > 0) m_debt[r] = m_debt[r] - 1;
                    else m_req[r] = 0;
                end
            end
        end
    end

    task automatic check(input string t, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        for (int r = 0; r < 2; r++) begin
            check(tag, req[r] == m_req[r][0], int'(req[r]), m_req[r]);
            check(tag, int'(debt[r*DW +: DW]) == m_debt[r], int'(debt[r*DW +: DW]), m_debt[r]);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0; hot = 1'b0; ack = 2'b00;
        repeat (3) cyc();
        tag = "R1";
        check("R1", req == 2'b00, int'(req), 0);
        check("R1", debt == 8'h00, int'(debt), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R2: first request exactly N cycles after release
        en = 1'b1; tag = "R2";
        for (int k = 1; k <= N; k++) begin
            cyc();
            check("R2", req[0] == (k >= N), int'(req[0]), int'(k >= N));
        end
        repeat (2 * N) cyc();
        // R6: debt grows to the cap and holds there
        tag = "R6";
        repeat (10 * N) cyc();
        check("R6", debt[3:0] == 4'd8, int'(debt[3:0]), 8);
        // R7 / R9: serve rank 0 only
        tag = "R7";
        for (int i = 0; i < 5; i++) begin
            ack = 2'b01; cyc(); ack = 2'b00; cyc();
        end
        check("R9", debt[7:4] == 4'd8, int'(debt[7:4]), 8);
        check("R7", req[0] == 1'b1, int'(req[0]), 1);

        // R4 / R3: hot flag raised mid-interval
        do_reset();
        en = 1'b1; tag = "R4";
        repeat (3) cyc();
        hot = 1'b1;
        for (int k = 4; k <= N; k++) begin
            cyc();
            check("R4", req[0] == (k >= N), int'(req[0]), int'(k >= N));
        end
        ack = 2'b11; tag = "R3";
        for (int m = 1; m <= HALF; m++) begin
            cyc();
            ack = 2'b00;
            check("R3", req[1] == (m >= HALF), int'(req[1]), int'(m >= HALF));
        end
        repeat (3 * N) cyc();

        // R8: enable low freezes timers, acks still served
        tag = "R8";
        en = 1'b0;
        repeat (3 * N) cyc();
        ack = 2'b10; cyc(); ack = 2'b00;
        repeat (2 * N) cyc();
        en = 1'b1;

        // R5: acknowledges while no request is pending
        tag = "R5";
        hot = 1'b0;
        for (int i = 0; i < 12; i++) begin ack = 2'b11; cyc(); end
        ack = 2'b00;
        for (int i = 0; i < 3 * N; i++) begin
            ack = {1'b0, req[0]}; cyc();
        end
        ack = 2'b00;

        // R9: pseudo-random sweep of every input
        tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            automatic int unsigned v = $urandom;
            en  = (v % 8) != 0;
            hot = ((v >> 4) % 64) < 20 ? ~hot : hot;
            ack = {((v >> 12) % 5) == 0, ((v >> 16) % 3) == 0};
            cyc();
        end

        // R1: reset in mid-run clears everything
        do_reset();
        tag = "R1";
        cyc();
        check("R1", req == 2'b00, int'(req), 0);
        check("R1", debt == 8'h00, int'(debt), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule